// File: doc/BRIEF.md
# Manual Reset Pulse Qualifier

This block turns a raw, active-low reset button (or a logic signal used the same way) into a clean single-bit request for a downstream reset sequencer. It runs on the system clock and uses a one-cycle strobe that arrives once per millisecond as its timebase. Short low glitches are thrown away. A low that lasts long enough raises the request. The request stays up while the input stays low.

When the input is released, the request is removed once the input has been steadily high for a short qualifying time. The downstream hold period then starts from that falling edge. Contact bounce around release cannot drop the request early, and it cannot make the request rise a second time. The raw input is synchronised before any counting, so it may change at any time with respect to the clock.

Top module: `manual_reset_qualifier`

## Requirements
- R1: A synchronous reset (`syncRst` high at a clock edge) forces `rstRequest` to 0 at that edge and clears all qualification progress, including while a request is active.
- R2: A low on `buttonN` shorter than one tick period never raises `rstRequest`, whatever its phase relative to the tick.
- R3: Any high sample of the synchronised input discards the accumulated low time, so a train of short lows separated by brief highs never raises `rstRequest`.
- R4: A low held for at least `ASSERT_TICKS` tick periods plus the synchroniser delay always raises `rstRequest`; this includes any low of 20 ticks.
- R5: `rstRequest` rises on the clock edge after the `ASSERT_TICKS`-th tick counted with the synchronised input low. With `SYNC_STAGES`=2, `ASSERT_TICKS`=4 and a tick every 10 cycles, that is 34 to 43 clock edges after the input falls.
- R6: While `buttonN` stays low, `rstRequest` stays at 1.
- R7: Once the request is active, it is removed only after `RELEASE_TICKS` consecutive ticks are seen with the synchronised input high; a low sample restarts that count.
- R8: After a clean release, `rstRequest` falls on the clock edge after the `RELEASE_TICKS`-th high tick. With the defaults and a 10-cycle tick, that is 14 to 23 edges after the input rises.
- R9: Without `tickMs` pulses, no amount of low time raises `rstRequest`; qualification advances only on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| syncRst | input | 1 | Synchronous reset, active high |
| tickMs | input | 1 | One-cycle strobe, once per millisecond |
| buttonN | input | 1 | Raw asynchronous reset input, active low |
| rstRequest | output | 1 | Qualified reset request, active high |

## Verification
The bench times how long the request takes to rise from several tick phases. A design that counted one tick too few or too many, or that skipped the synchroniser, would land outside the 34 to 43 edge window. Glitch trains made of lows of almost a full tick period, each separated by three-cycle highs, expose a counter that forgets to clear and so slowly accumulates a false request. Bounce patterns after release catch a release counter that is not cleared by a low sample, which would drop the request during the bounce. A run with the tick held off exposes any counting on the plain clock.

// File: rtl/mrq_pkg.sv
package mrq_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic lowCountEn;
    logic highCountEn;
  } strobeT;

  typedef enum logic {
    WAIT_LOW = 1'b0,
    HOLD_REQ = 1'b1
  } stateT;

endpackage

// File: rtl/mrq_tick_counter.sv
module mrq_tick_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic syncRst,
  input  logic clear,
  input  logic advance,
  output logic done
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

  logic [CNT_W-1:0] count;

  always_ff @(posedge clk) begin
    if (syncRst || clear) begin
      count <= '0;
    end else if (advance && (count != LIMIT_V)) begin
      count <= count + 1'b1;
    end
  end

  assign done = (count == LIMIT_V);
endmodule

// File: rtl/mrq_datapath.sv
module mrq_datapath
  import mrq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int ASSERT_TICKS  = 4,
  parameter int RELEASE_TICKS = 2
) (
  input  logic   clk,
  input  logic   syncRst,
  input  logic   tickMs,
  input  logic   buttonN,
  input  strobeT strobe,
  output logic   syncLow,
  output logic   lowDone,
  output logic   highDone
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (syncRst) syncChain <= '1;
        else         syncChain <= buttonN;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (syncRst) syncChain <= '1;
        else         syncChain <= {syncChain[LAST-1:0], buttonN};
      end
    end
  endgenerate

  assign syncLow = ~syncChain[LAST];

  // time spent low, discarded by any high sample
  mrq_tick_counter #(.LIMIT(ASSERT_TICKS)) u_lowCnt (
    .clk     (clk),
    .syncRst (syncRst),
    .clear   (~syncLow),
    .advance (tickMs & strobe.lowCountEn),
    .done    (lowDone)
  );

  // time spent high after a request, discarded by any low sample
  mrq_tick_counter #(.LIMIT(RELEASE_TICKS)) u_highCnt (
    .clk     (clk),
    .syncRst (syncRst),
    .clear   (syncLow),
    .advance (tickMs & strobe.highCountEn),
    .done    (highDone)
  );
endmodule

// File: rtl/mrq_control.sv
module mrq_control
  import mrq_pkg::*;
(
  input  logic   clk,
  input  logic   syncRst,
  input  logic   syncLow,
  input  logic   lowDone,
  input  logic   highDone,
  output strobeT strobe,
  output logic   rstRequest
);
  stateT state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      WAIT_LOW: if (lowDone && syncLow)   stateNext = HOLD_REQ;
      HOLD_REQ: if (highDone && !syncLow) stateNext = WAIT_LOW;
      default:                            stateNext = WAIT_LOW;
    endcase
  end

  always_ff @(posedge clk) begin
    if (syncRst) state <= WAIT_LOW;
    else         state <= stateNext;
  end

  assign strobe.lowCountEn  = (state == WAIT_LOW);
  assign strobe.highCountEn = (state == HOLD_REQ);
  assign rstRequest         = (state == HOLD_REQ);
endmodule

// File: rtl/manual_reset_qualifier.sv
module manual_reset_qualifier
  import mrq_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int ASSERT_TICKS  = 4,
  parameter int RELEASE_TICKS = 2
) (
  input  logic clk,
  input  logic syncRst,
  input  logic tickMs,
  input  logic buttonN,
  output logic rstRequest
);
  strobeT strobe;
  logic   syncLow;
  logic   lowDone;
  logic   highDone;

  mrq_datapath #(
    .SYNC_STAGES   (SYNC_STAGES),
    .ASSERT_TICKS  (ASSERT_TICKS),
    .RELEASE_TICKS (RELEASE_TICKS)
  ) u_dp (
    .clk      (clk),
    .syncRst  (syncRst),
    .tickMs   (tickMs),
    .buttonN  (buttonN),
    .strobe   (strobe),
    .syncLow  (syncLow),
    .lowDone  (lowDone),
    .highDone (highDone)
  );

  mrq_control u_ctrl (
    .clk        (clk),
    .syncRst    (syncRst),
    .syncLow    (syncLow),
    .lowDone    (lowDone),
    .highDone   (highDone),
    .strobe     (strobe),
    .rstRequest (rstRequest)
  );
endmodule

// File: rtl/mrq_checker.sv
module mrq_checker (
  input logic clk,
  input logic syncRst,
  input logic tickMs,
  input logic syncLow,
  input logic rstRequest
);
  // R1
  reset_drops_request_chk: assert property (@(posedge clk)
    syncRst |=> !rstRequest);

  // R5
  rise_follows_tick_chk: assert property (@(posedge clk) disable iff (syncRst)
    ($rose(rstRequest) && !$past(syncRst)) |-> $past(tickMs, 2));

  // R6
  held_while_low_chk: assert property (@(posedge clk) disable iff (syncRst)
    (rstRequest && syncLow) |=> rstRequest);

  // R7
  fall_needs_high_chk: assert property (@(posedge clk) disable iff (syncRst)
    ($fell(rstRequest) && !$past(syncRst)) |-> !$past(syncLow));

  // R3
  no_rise_when_high_chk: assert property (@(posedge clk) disable iff (syncRst)
    ($rose(rstRequest) && !$past(syncRst)) |-> $past(syncLow));
endmodule

bind manual_reset_qualifier mrq_checker u_chk (
  .clk        (clk),
  .syncRst    (syncRst),
  .tickMs     (tickMs),
  .syncLow    (syncLow),
  .rstRequest (rstRequest)
);

// File: tb/manual_reset_qualifier_tb.sv
`timescale 1ns/1ps
module manual_reset_qualifier_tb;
  localparam int TICK_DIV = 10;

  logic clk = 1'b0;
  logic syncRst = 1'b1;
  logic tickMs = 1'b0;
  logic buttonN = 1'b1;
  logic rstRequest;
  logic tickEn = 1'b1;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  manual_reset_qualifier u_dut (
    .clk        (clk),
    .syncRst    (syncRst),
    .tickMs     (tickMs),
    .buttonN    (buttonN),
    .rstRequest (rstRequest)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (TICK_DIV - 1) @(negedge clk);
      tickMs = tickEn;
      @(negedge clk);
      tickMs = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1
  task automatic t_reset();
    syncRst = 1'b1; buttonN = 1'b1;
    idle(3);
    check(rstRequest == 1'b0, "R1 reset state", rstRequest, 0);
    syncRst = 1'b0;
    idle(30);
    check(rstRequest == 1'b0, "R1 idle after reset", rstRequest, 0);
  endtask

  // R2
  task automatic t_glitch(input int phase);
    int seen = 0;
    idle(phase);
    buttonN = 1'b0;
    idle(TICK_DIV - 1);
    buttonN = 1'b1;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (rstRequest) seen++;
    end
    check(seen == 0, "R2 short low ignored", seen, 0);
  endtask

  // R3
  task automatic t_fragments();
    int seen = 0;
    for (int k = 0; k < 20; k++) begin
      buttonN = 1'b0;
      for (int i = 0; i < 9; i++) begin @(negedge clk); if (rstRequest) seen++; end
      buttonN = 1'b1;
      for (int i = 0; i < 3; i++) begin @(negedge clk); if (rstRequest) seen++; end
    end
    idle(40);
    check(seen == 0 && rstRequest == 1'b0, "R3 fragmented lows ignored", seen, 0);
  endtask

  // R8 after release completes
  task automatic release_clean();
    int n = 0;
    buttonN = 1'b1;
    idle(13);
    check(rstRequest == 1'b1, "R8 still held 13 edges after release", rstRequest, 1);
    idle(10);
    n = rstRequest;
    check(n == 0, "R8 removed by 23 edges after release", n, 0);
    idle(20);
  endtask

  // R4, R5
  task automatic t_latency(input int phase);
    int n = 0;
    idle(phase);
    buttonN = 1'b0;
    while (!rstRequest && n < 300) begin
      @(negedge clk);
      n++;
    end
    check(rstRequest == 1'b1, "R4 request raised by steady low", rstRequest, 1);
    check(n >= 34 && n <= 43, "R5 rise latency in edges", n, 38);
    release_clean();
  endtask

  // R4, R6
  task automatic t_hold_long();
    int drops = 0;
    buttonN = 1'b0;
    idle(45);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!rstRequest) drops++;
    end
    check(drops == 0, "R6 held while low for 20 ticks", drops, 0);
    check(rstRequest == 1'b1, "R4 20-tick low accepted", rstRequest, 1);
  endtask

  // R7
  task automatic t_bounce();
    int drops = 0;
    for (int k = 0; k < 8; k++) begin
      buttonN = 1'b1;
      for (int i = 0; i < 5; i++) begin @(negedge clk); if (!rstRequest) drops++; end
      buttonN = 1'b0;
      for (int i = 0; i < 4; i++) begin @(negedge clk); if (!rstRequest) drops++; end
    end
    check(drops == 0, "R7 bounce does not release", drops, 0);
    release_clean();
    check(rstRequest == 1'b0, "R7 no retrigger after bounce", rstRequest, 0);
  endtask

  // R9
  task automatic t_no_tick();
    int seen = 0;
    int n = 0;
    tickEn = 1'b0;
    idle(2);
    buttonN = 1'b0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); if (rstRequest) seen++; end
    check(seen == 0, "R9 no request without ticks", seen, 0);
    tickEn = 1'b1;
    while (!rstRequest && n < 100) begin @(negedge clk); n++; end
    check(rstRequest == 1'b1 && n <= 42, "R9 counting resumes with ticks", n, 35);
    release_clean();
  endtask

  // R1 during an active request
  task automatic t_reset_active();
    buttonN = 1'b0;
    idle(60);
    check(rstRequest == 1'b1, "R1 precondition request active", rstRequest, 1);
    syncRst = 1'b1;
    idle(1);
    check(rstRequest == 1'b0, "R1 reset clears active request", rstRequest, 0);
    syncRst = 1'b0;
    buttonN = 1'b1;
    idle(60);
    check(rstRequest == 1'b0, "R1 no request after reset and release", rstRequest, 0);
  endtask

  initial begin
    idle(1);
    t_reset();
    for (int p = 0; p < 5; p++) t_glitch(p * 3);
    t_fragments();
    for (int p = 0; p < 4; p++) t_latency(p * 4 + 1);
    t_hold_long();
    t_bounce();
    t_no_tick();
    t_reset_active();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule